// File: doc/BRIEF.md
# Blocking FIFO Storage Cell

This block is a small shared queue cell that several hardware threads reach through load and store requests. Each request carries a thread number. A store pushes a word onto the tail of the queue, and a load pops the word at the head. Every request selects one of two access views.

In the waiting view, a load that finds the queue empty does not complete. Nor does a store that finds it full. In either case the cell answers "blocked" and records the issuing thread in a reader or writer wait mask. In the non-waiting view, a store to a full queue is dropped without notice, and a load from an empty queue returns zero. Neither case records the thread.

Two tag bits, empty and full, follow the occupancy. A successful push releases every waiting reader with a one-cycle wake pulse and clears the reader mask. A successful pop does the same for waiting writers. The threads that were woken retry their access.

Top module: `fifo_gate_cell`

## Requirements
- R1: A request is taken when `req_valid` is 1 at a rising edge, with `req_op` 0 for a load and 1 for a store. The response (`rsp_valid`, `rsp_data`, `rsp_blocked`) appears after that edge and lasts one cycle. A successful load returns the oldest stored word.
- R2: `cell_empty` is 1 exactly when the queue holds no entries, and `cell_full` is 1 exactly when it holds DEPTH entries. Both are valid in the cycle after the edge that accepted the push or pop.
- R3: A waiting-view load (`req_view` 0) on an empty queue answers `rsp_blocked`=1 with data 0 and pops nothing. It also sets bit `req_tid` of `blk_rd_map`.
- R4: A waiting-view store on a full queue answers `rsp_blocked`=1 and does not store its data. It also sets bit `req_tid` of `blk_wr_map`.
- R5: A non-waiting-view store (`req_view` 1) on a full queue answers `rsp_blocked`=0. It leaves the queue contents, the tag bits and both masks unchanged.
- R6: A non-waiting-view load on an empty queue answers data 0 with `rsp_blocked`=0. It leaves both masks unchanged.
- R7: A successful push drives `wake_rd` for one cycle with the reader mask as it stood before the push. In the same step the push clears `blk_rd_map`.
- R8: A successful pop drives `wake_wr` for one cycle with the writer mask as it stood before the pop. In the same step the pop clears `blk_wr_map`, and the response to that pop carries its data in the same cycle.
- R9: After reset the queue is empty: `cell_empty`=1, `cell_full`=0, both masks and both wake vectors are 0, and `rsp_valid` is 0.
- R10: First-in first-out order holds across more pushes and pops than DEPTH, as the read and write positions wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_tid | input | TID_W | Issuing thread number |
| req_op | input | 1 | 0 load (pop), 1 store (push) |
| req_view | input | 1 | 0 waiting view, 1 non-waiting view |
| req_data | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W | Load data, zero when nothing was popped |
| rsp_blocked | output | 1 | Issuing thread must wait |
| wake_rd | output | NTHR | One-cycle release of waiting readers |
| wake_wr | output | NTHR | One-cycle release of waiting writers |
| blk_rd_map | output | NTHR | Threads waiting to load |
| blk_wr_map | output | NTHR | Threads waiting to store |
| cell_empty | output | 1 | Queue holds no entries |
| cell_full | output | 1 | Queue holds DEPTH entries |

## Verification
Two functions can land in the same cycle: the data response of a pop, and the release of the writers that the pop frees. The bench provokes this by filling the queue and parking a thread on a waiting-view store. It then issues one load. In the single cycle after that load it judges that the response carries the head word, that `wake_wr` carries the parked thread's bit, and that the writer mask has already returned to zero. The push side is checked the same way, with two parked readers released together by one store.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
    localparam int DATA_W = 32;
    localparam int NTHR   = 8;
    localparam int TID_W  = $clog2(NTHR);

    typedef enum logic { OP_LOAD = 1'b0, OP_STORE = 1'b1 } op_e;
    typedef enum logic { VIEW_WAIT = 1'b0, VIEW_TRY = 1'b1 } view_e;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [NTHR-1:0]   tmask_t;
    typedef logic [TID_W-1:0]  tid_t;

    typedef struct packed {
        logic  valid;
        tid_t  tid;
        op_e   op;
        view_e view;
        word_t data;
    } req_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic block;
    } act_t;

    function automatic tmask_t tid_bit(input tid_t t);
        return tmask_t'(1) << t;
    endfunction
endpackage

// File: rtl/fgc_decide.sv
module fgc_decide
    import fgc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             valid,
    input  op_e              op,
    input  view_e            view,
    input  logic [CNT_W-1:0] cnt,
    output act_t             act
);
    logic room;
    logic avail;

    always_comb begin
        room      = (cnt != CNT_W'(DEPTH));
        avail     = (cnt != '0);
        act.push  = valid && (op == OP_STORE) && room;
        act.pop   = valid && (op == OP_LOAD) && avail;
        act.block = valid && (view == VIEW_WAIT) &&
                    ((op == OP_STORE) ? !room : !avail);
    end
endmodule

// File: rtl/fgc_ring.sv
module fgc_ring
    import fgc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  word_t            wdata,
    output word_t            head,
    output logic [CNT_W-1:0] cnt
);
    word_t            slots [DEPTH];
    logic [DEPTH-1:0] slot_we;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_we
        assign slot_we[i] = push && (wptr == PTR_W'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) slots[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= step(wptr);
            if (pop)  rptr <= step(rptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head = slots[rptr];
endmodule

// File: rtl/fgc_waitmap.sv
module fgc_waitmap
    import fgc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  logic   pop,
    input  logic   block,
    input  op_e    op,
    input  tid_t   tid,
    output tmask_t rd_map,
    output tmask_t wr_map,
    output tmask_t wake_rd,
    output tmask_t wake_wr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_map  <= '0;
            wr_map  <= '0;
            wake_rd <= '0;
            wake_wr <= '0;
        end else begin
            wake_rd <= push ? rd_map : '0;
            wake_wr <= pop  ? wr_map : '0;
            if (push)
                rd_map <= '0;
            else if (block && op == OP_LOAD)
                rd_map <= rd_map | tid_bit(tid);
            if (pop)
                wr_map <= '0;
            else if (block && op == OP_STORE)
                wr_map <= wr_map | tid_bit(tid);
        end
    end
endmodule

// File: rtl/fifo_gate_cell.sv
module fifo_gate_cell
    import fgc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [TID_W-1:0]  req_tid,
    input  logic              req_op,
    input  logic              req_view,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_blocked,
    output logic [NTHR-1:0]   wake_rd,
    output logic [NTHR-1:0]   wake_wr,
    output logic [NTHR-1:0]   blk_rd_map,
    output logic [NTHR-1:0]   blk_wr_map,
    output logic              cell_empty,
    output logic              cell_full
);
    req_t             req;
    act_t             act;
    word_t            head;
    logic [CNT_W-1:0] cnt;

    assign req = '{valid: req_valid, tid: req_tid, op: op_e'(req_op),
                   view: view_e'(req_view), data: req_data};

    fgc_decide #(.DEPTH(DEPTH)) u_decide (
        .valid (req.valid),
        .op    (req.op),
        .view  (req.view),
        .cnt   (cnt),
        .act   (act)
    );

    fgc_ring #(.DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .push  (act.push),
        .pop   (act.pop),
        .wdata (req.data),
        .head  (head),
        .cnt   (cnt)
    );

    fgc_waitmap u_wait (
        .clk     (clk),
        .rst     (rst),
        .push    (act.push),
        .pop     (act.pop),
        .block   (act.block),
        .op      (req.op),
        .tid     (req.tid),
        .rd_map  (blk_rd_map),
        .wr_map  (blk_wr_map),
        .wake_rd (wake_rd),
        .wake_wr (wake_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_data    <= '0;
            rsp_blocked <= 1'b0;
        end else begin
            rsp_valid   <= req.valid;
            rsp_data    <= act.pop ? head : '0;
            rsp_blocked <= act.block;
        end
    end

    assign cell_empty = (cnt == '0);
    assign cell_full  = (cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/fgc_chk.sv
module fgc_chk
    import fgc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_op,
    input logic              req_view,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_blocked,
    input logic [NTHR-1:0]   wake_rd,
    input logic [NTHR-1:0]   wake_wr,
    input logic [NTHR-1:0]   blk_rd_map,
    input logic [NTHR-1:0]   blk_wr_map,
    input logic              cell_empty,
    input logic              cell_full
);
    // R2
    tags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(cell_empty && cell_full));

    // R3
    blocked_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_blocked |-> (rsp_valid && rsp_data == '0));

    // R4
    full_store_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op && cell_full) |=> cell_full);

    // R5
    try_store_no_block_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op && req_view) |=> !rsp_blocked);

    // R6
    empty_load_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_op && cell_empty) |=> (cell_empty && rsp_data == '0));

    // R7
    rd_wake_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_rd != '0) |-> (blk_rd_map == '0 && !cell_empty));

    // R8
    wr_wake_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_wr != '0) |-> (blk_wr_map == '0 && !cell_full));

    // R7
    wake_one_side_chk: assert property (@(posedge clk) disable iff (rst)
        !((wake_rd != '0) && (wake_wr != '0)));
endmodule

bind fifo_gate_cell fgc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_view    (req_view),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_blocked (rsp_blocked),
    .wake_rd     (wake_rd),
    .wake_wr     (wake_wr),
    .blk_rd_map  (blk_rd_map),
    .blk_wr_map  (blk_wr_map),
    .cell_empty  (cell_empty),
    .cell_full   (cell_full)
);

// File: tb/tb_fifo_gate_cell.sv
module tb_fifo_gate_cell;
    import fgc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [TID_W-1:0]  req_tid = '0;
    logic              req_op = 1'b0;
    logic              req_view = 1'b0;
    logic [DATA_W-1:0] req_data = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_blocked;
    logic [NTHR-1:0]   wake_rd;
    logic [NTHR-1:0]   wake_wr;
    logic [NTHR-1:0]   blk_rd_map;
    logic [NTHR-1:0]   blk_wr_map;
    logic              cell_empty;
    logic              cell_full;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    fifo_gate_cell #(.DEPTH(4)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid),
        .req_op(req_op), .req_view(req_view), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_blocked(rsp_blocked),
        .wake_rd(wake_rd), .wake_wr(wake_wr), .blk_rd_map(blk_rd_map),
        .blk_wr_map(blk_wr_map), .cell_empty(cell_empty), .cell_full(cell_full)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge take it, sample at the next falling edge.
    task automatic issue(input int tid, input bit store, input bit try_view, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_tid   = TID_W'(tid);
        req_op    = store;
        req_view  = try_view;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 empty", 32'(cell_empty), 32'd1);
        check("R9 full", 32'(cell_full), 32'd0);
        check("R9 rdmap", 32'(blk_rd_map), 32'd0);
        check("R9 wrmap", 32'(blk_wr_map), 32'd0);
        check("R9 wake", 32'({wake_rd, wake_wr}), 32'd0);
        check("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_order;
        for (int i = 0; i < 4; i++) begin
            issue(0, 1, 0, 32'hA0 + i);
            check("R1 store not blocked", 32'(rsp_blocked), 32'd0);
            check("R2 empty after push", 32'(cell_empty), 32'd0);
            check("R2 full after push", 32'(cell_full), (i == 3) ? 32'd1 : 32'd0);
        end
        for (int i = 0; i < 4; i++) begin
            issue(1, 0, 0, 32'h0);
            check("R1 rsp_valid", 32'(rsp_valid), 32'd1);
            check("R1 pop order", rsp_data, 32'hA0 + i);
            check("R2 empty after pop", 32'(cell_empty), (i == 3) ? 32'd1 : 32'd0);
            check("R2 full after pop", 32'(cell_full), 32'd0);
        end
    endtask

    task automatic t_try_empty;
        issue(4, 0, 1, 32'h0);
        check("R6 data", rsp_data, 32'd0);
        check("R6 blocked", 32'(rsp_blocked), 32'd0);
        check("R6 rdmap", 32'(blk_rd_map), 32'd0);
        check("R6 still empty", 32'(cell_empty), 32'd1);
    endtask

    task automatic t_read_block;
        issue(3, 0, 0, 32'h0);
        check("R3 blocked", 32'(rsp_blocked), 32'd1);
        check("R3 data", rsp_data, 32'd0);
        check("R3 rdmap", 32'(blk_rd_map), 32'h08);
        issue(5, 0, 0, 32'h0);
        check("R3 rdmap two", 32'(blk_rd_map), 32'h28);
        check("R3 still empty", 32'(cell_empty), 32'd1);
        issue(1, 1, 0, 32'h55);
        check("R7 wake_rd", 32'(wake_rd), 32'h28);
        check("R7 rdmap cleared", 32'(blk_rd_map), 32'd0);
        check("R7 wake_wr quiet", 32'(wake_wr), 32'd0);
        issue(3, 0, 0, 32'h0);
        check("R7 pulse ended", 32'(wake_rd), 32'd0);
        check("R1 retry data", rsp_data, 32'h55);
    endtask

    task automatic t_full;
        for (int i = 0; i < 4; i++) issue(0, 1, 0, 32'hB0 + i);
        check("R2 full", 32'(cell_full), 32'd1);
        issue(2, 1, 1, 32'hDEAD);
        check("R5 not blocked", 32'(rsp_blocked), 32'd0);
        check("R5 still full", 32'(cell_full), 32'd1);
        check("R5 wrmap", 32'(blk_wr_map), 32'd0);
        issue(6, 1, 0, 32'hBEEF);
        check("R4 blocked", 32'(rsp_blocked), 32'd1);
        check("R4 wrmap", 32'(blk_wr_map), 32'h40);
        issue(7, 0, 0, 32'h0);
        check("R8 pop data", rsp_data, 32'hB0);
        check("R8 wake_wr", 32'(wake_wr), 32'h40);
        check("R8 wrmap cleared", 32'(blk_wr_map), 32'd0);
        check("R8 not full", 32'(cell_full), 32'd0);
        for (int i = 1; i < 4; i++) begin
            issue(7, 0, 0, 32'h0);
            check("R4 R5 dropped data absent", rsp_data, 32'hB0 + i);
        end
        check("R8 pulse ended", 32'(wake_wr), 32'd0);
        check("R2 empty again", 32'(cell_empty), 32'd1);
    endtask

    task automatic t_wrap;
        issue(0, 1, 0, 32'hC0);
        issue(0, 1, 0, 32'hC1);
        for (int i = 0; i < 8; i++) begin
            issue(0, 1, 0, 32'hC2 + i);
            issue(1, 0, 0, 32'h0);
            check("R10 wrap order", rsp_data, 32'hC0 + i);
        end
        issue(1, 0, 0, 32'h0);
        check("R10 tail a", rsp_data, 32'hC8);
        issue(1, 0, 0, 32'h0);
        check("R10 tail b", rsp_data, 32'hC9);
        check("R10 empty", 32'(cell_empty), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_try_empty();
        t_read_block();
        t_full();
        t_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule